// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Code Register

This block is the digital front end of a 16-bit converter loaded over a parallel bus. A host presents a data word together with active-low strobes: a write strobe, a select for the upper byte, a select for the lower byte, a load strobe and a clear. The two halves of the word land in separate byte-wide staging registers, and a separate load strobe copies both staged bytes into the output code register that drives the converter. A host with only an 8-bit bus ties each upper bus bit to its matching lower bit and fills the two halves with two writes, one per select.

The block is clocked. It samples the strobes on every rising edge and reproduces the level-sensitive behaviour of a latch-based interface. When write, both selects and load are all low together, the bus word reaches the output in a single clock. Clear forces all three registers to zero at once, with no clock needed, and they leave the cleared state on a clock edge. A power-on reset input has the same effect on the registers. A pulse-width monitor counts how many clock samples each strobe stays low. It keeps one sticky flag per strobe that records any low pulse shorter than the minimum, where the minimum in cycles comes from a nanosecond figure and the clock period.

Top module: `dacfe_top`

## Requirements
- R1: While `por_n` is low, and after it is released, `code_q` reads 0 and all five bits of `pw_err` read 0.
- R2: A rising edge that samples `wr_n` low and `csl_n` low stores `bus_d[7:0]` in the lower staging byte.
- R3: A rising edge that samples `wr_n` low and `csh_n` low stores `bus_d[15:8]` in the upper staging byte.
- R4: A rising edge that samples both selects low with `wr_n` low stores both bytes. A rising edge that samples `wr_n` high, or both selects high, leaves both staging bytes unchanged.
- R5: A rising edge that samples `ld_n` low sets `code_q` to {upper byte, lower byte}, using any byte written at that same edge. A rising edge that samples `ld_n` high leaves `code_q` unchanged.
- R6: A rising edge that samples `wr_n`, `csl_n`, `csh_n` and `ld_n` all low puts `bus_d` on `code_q` after that single edge.
- R7: A low on `clr_n` forces `code_q` and both staging bytes to 0 at once, with no clock edge needed. After `clr_n` returns high, the first two rising edges are ignored and the third is the first that updates the registers.
- R8: An 8-bit host that drives `bus_d` as {b, b} can fill the upper and lower bytes with two separate select pulses, then load them as one word.
- R9: `pw_err` has one bit per strobe: bit 0 for `wr_n`, bit 1 for `csl_n`, bit 2 for `csh_n`, bit 3 for `ld_n` and bit 4 for `clr_n`. The minimum pulse length is ceil(MIN_PULSE_NS*1000/CLK_PERIOD_PS) clock samples, which is 6 at the defaults. A bit is set at the rising edge that first samples its strobe high after a low run shorter than the minimum. A run of at least the minimum sets nothing.
- R10: The `pw_err` bits are sticky. `clr_n` does not reset them; only `por_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_d | input | 16 | Parallel data word |
| wr_n | input | 1 | Write strobe, active low |
| csl_n | input | 1 | Lower-byte select, active low |
| csh_n | input | 1 | Upper-byte select, active low |
| ld_n | input | 1 | Load strobe into the output register, active low |
| clr_n | input | 1 | Clear, active low, asynchronous |
| code_q | output | 16 | Output code to the converter |
| pw_err | output | 5 | Sticky short-pulse flags, one per strobe |

## Verification
A write or load that a rising edge samples shows on `code_q` after that one edge. The bench drives the strobes and the bus on the falling edge and compares outputs on the following falling edge, so the comparison lands between two edges. Clear is checked one nanosecond after `clr_n` falls, before any clock edge, and its release is checked after the second and after the third rising edge. A `pw_err` bit is due just after the first edge that samples its strobe high again. It is checked one half-cycle after that edge, and also one cycle before it to confirm that it is not set early.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // strobe indices inside the pulse monitor vector
    localparam int unsigned N_STROBE = 5;
    localparam int unsigned IDX_WR   = 0;
    localparam int unsigned IDX_CSL  = 1;
    localparam int unsigned IDX_CSH  = 2;
    localparam int unsigned IDX_LD   = 3;
    localparam int unsigned IDX_CLR  = 4;

    // minimum low run in clock samples, rounded up, never below one
    function automatic int unsigned min_low_cycles(input int unsigned pulse_ns,
                                                   input int unsigned clk_ps);
        int unsigned c;
        c = (pulse_ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/dacfe_rst_sync.sv
module dacfe_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic              wr_n,
    input  logic              csl_n,
    input  logic              csh_n,
    input  logic              ld_n,
    output logic [DATA_W-1:0] code_q
);
    localparam int unsigned BYTE_W = DATA_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [DATA_W-1:0] code;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_lo, wr_hi;

    always_comb begin
        st_d  = st_q;
        wr_lo = !wr_n && !csl_n;
        wr_hi = !wr_n && !csh_n;
        if (wr_lo) st_d.lo = bus_d[BYTE_W-1:0];
        if (wr_hi) st_d.hi = bus_d[DATA_W-1:BYTE_W];
        // load takes the next-state bytes: flow-through in one clock
        if (!ld_n) st_d.code = {st_d.hi, st_d.lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_q = st_q.code;

    a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !csl_n) |=> (st_q.lo == $past(bus_d[BYTE_W-1:0])));

    a_r3_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !csh_n) |=> (st_q.hi == $past(bus_d[DATA_W-1:BYTE_W])));

    a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n || (csl_n && csh_n)) |=> $stable({st_q.hi, st_q.lo}));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(code_q));

    a_r6_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !csl_n && !csh_n && !ld_n) |=> (code_q == $past(bus_d)));

endmodule

// File: rtl/dacfe_pw_chk.sv
module dacfe_pw_chk #(
    parameter int unsigned MIN_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic err_q
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
    } chk_t;

    chk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!strobe_n) begin
            if (st_q.cnt < MIN_V) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            if (st_q.cnt != '0 && st_q.cnt < MIN_V) st_d.err = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_q = st_q.err;

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9: a strobe still low cannot raise its flag
    a_r9_low_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && !strobe_n) |=> !err_q);

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned MIN_PULSE_NS  = 60
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic              wr_n,
    input  logic              csl_n,
    input  logic              csh_n,
    input  logic              ld_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] code_q,
    output logic [dacfe_pkg::N_STROBE-1:0] pw_err
);
    import dacfe_pkg::*;

    localparam int unsigned MIN_CYC = min_low_cycles(MIN_PULSE_NS, CLK_PERIOD_PS);

    logic core_arst_n, core_rst_n, mon_rst_n;
    logic [N_STROBE-1:0] strb_n;

    assign core_arst_n = por_n && clr_n;

    dacfe_rst_sync #(.STAGES(2)) u_core_rst (
        .clk    (clk),
        .arst_n (core_arst_n),
        .srst_n (core_rst_n)
    );

    dacfe_rst_sync #(.STAGES(2)) u_mon_rst (
        .clk    (clk),
        .arst_n (por_n),
        .srst_n (mon_rst_n)
    );

    dacfe_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (core_rst_n),
        .bus_d  (bus_d),
        .wr_n   (wr_n),
        .csl_n  (csl_n),
        .csh_n  (csh_n),
        .ld_n   (ld_n),
        .code_q (code_q)
    );

    always_comb begin
        strb_n          = '1;
        strb_n[IDX_WR]  = wr_n;
        strb_n[IDX_CSL] = csl_n;
        strb_n[IDX_CSH] = csh_n;
        strb_n[IDX_LD]  = ld_n;
        strb_n[IDX_CLR] = clr_n;
    end

    for (genvar g = 0; g < N_STROBE; g++) begin : g_mon
        dacfe_pw_chk #(.MIN_CYC(MIN_CYC)) u_chk (
            .clk      (clk),
            .rst_n    (mon_rst_n),
            .strobe_n (strb_n[g]),
            .err_q    (pw_err[g])
        );
    end

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
        !clr_n |-> (code_q == '0));

    a_r1_por_zero: assert property (@(posedge clk)
        !por_n |-> (code_q == '0 && pw_err == '0));

endmodule

// File: tb/dacfe_top_test.sv
`timescale 1ns/1ps
module dacfe_top_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [15:0] bus_d = '0;
    logic        wr_n = 1'b1, csl_n = 1'b1, csh_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_q;
    logic [4:0]  pw_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_lo, m_hi;
    logic [15:0] m_code;

    dacfe_top uut (
        .clk(clk), .por_n(por_n), .bus_d(bus_d), .wr_n(wr_n), .csl_n(csl_n),
        .csh_n(csh_n), .ld_n(ld_n), .clr_n(clr_n), .code_q(code_q), .pw_err(pw_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected-value model taken from R2..R6
    function automatic void model(input logic w, input logic l, input logic h,
                                  input logic d, input logic [15:0] b);
        if (!w && !l) m_lo = b[7:0];
        if (!w && !h) m_hi = b[15:8];
        if (!d) m_code = {m_hi, m_lo};
    endfunction

    task automatic drive(input logic w, input logic l, input logic h,
                         input logic d, input logic [15:0] b);
        wr_n = w; csl_n = l; csh_n = h; ld_n = d; bus_d = b;
        model(w, l, h, d, b);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic w, input logic l, input logic h,
                        input logic d, input logic [15:0] b);
        drive(w, l, h, d, b);
        tick();
        drive(1, 1, 1, 1, b);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0DE5EED));
        m_lo = '0; m_hi = '0; m_code = '0;
        #1;
        chk("R1 code during por", code_q, 16'h0);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (3) tick();
        chk("R1 code after por", code_q, 16'h0);
        chk("R1 flags after por", {11'h0, pw_err}, 16'h0);

        // R9: long pulse (6 samples) of write with no select: no flag, no write
        drive(0, 1, 1, 1, 16'hFFFF);
        repeat (6) tick();
        drive(1, 1, 1, 1, 16'hFFFF);
        tick();
        chk("R9 long wr pulse no flag", {11'h0, pw_err}, 16'h0);
        // R9: 5-sample load pulse sets bit 3 on the edge that samples it high
        drive(1, 1, 1, 0, 16'h0);
        repeat (5) tick();
        chk("R9 flag not early", {11'h0, pw_err}, 16'h0);
        drive(1, 1, 1, 1, 16'h0);
        tick();
        chk("R9 short ld flag", {11'h0, pw_err}, 16'h0008);
        chk("R5 load of empty bytes", code_q, 16'h0);
        // R9/R10: short clear sets bit 4 and leaves bit 3
        clr_n = 1'b0;
        repeat (2) tick();
        clr_n = 1'b1;
        tick();
        chk("R10 clr keeps flag, R9 clr flag", {11'h0, pw_err}, 16'h0018);
        repeat (2) tick();

        // R2 lower byte, held by R5 until load
        step(0, 0, 1, 1, 16'h77A5);
        chk("R5 hold without load", code_q, 16'h0);
        step(1, 1, 1, 0, 16'h0);
        chk("R2 lower byte", code_q, 16'h00A5);
        // R3 upper byte
        step(0, 1, 0, 1, 16'h3C99);
        step(1, 1, 1, 0, 16'h0);
        chk("R3 upper byte", code_q, 16'h3CA5);
        // R4 both bytes, then writes inhibited
        step(0, 0, 0, 1, 16'h1234);
        step(1, 1, 1, 0, 16'h0);
        chk("R4 both bytes", code_q, 16'h1234);
        step(1, 0, 0, 1, 16'hDEAD);
        step(0, 1, 1, 1, 16'hBEAD);
        step(1, 1, 1, 0, 16'h0);
        chk("R4 inhibited writes", code_q, 16'h1234);
        // R5 load uses byte written at same edge
        step(0, 0, 1, 0, 16'hFF5E);
        chk("R5 same-edge load", code_q, 16'h125E);
        // R6 flow-through
        step(0, 0, 0, 0, 16'hBEEF);
        chk("R6 flow through", code_q, 16'hBEEF);
        // R8 8-bit host
        step(0, 0, 1, 1, 16'h1111);
        step(0, 1, 0, 1, 16'h2222);
        chk("R8 held before load", code_q, 16'hBEEF);
        step(1, 1, 1, 0, 16'h0);
        chk("R8 byte-wide host", code_q, 16'h2211);

        // R7 asynchronous clear
        clr_n = 1'b0;
        #1;
        chk("R7 clear without clock", code_q, 16'h0);
        m_lo = '0; m_hi = '0; m_code = '0;
        repeat (2) tick();
        drive(0, 0, 0, 0, 16'h5A5A);
        clr_n = 1'b1;
        tick();
        tick();
        chk("R7 second edge ignored", code_q, 16'h0);
        tick();
        chk("R7 third edge updates", code_q, 16'h5A5A);
        drive(1, 1, 1, 1, 16'h0);
        tick();

        // random traffic against the model (R2..R6)
        for (int i = 0; i < 600; i++) begin
            logic [15:0] b;
            logic [3:0]  s;
            b = 16'($urandom);
            s = 4'($urandom);
            drive(s[0], s[1], s[2], s[3], b);
            tick();
            chk("R2/R3/R4/R5/R6 random", code_q, m_code);
        end
        drive(1, 1, 1, 1, 16'h0);
        tick();
        chk("R10 flags still set", {11'h0, pw_err} & 16'h0018, 16'h0018);
        por_n = 1'b0;
        #1;
        chk("R10 por clears flags", {11'h0, pw_err}, 16'h0);
        chk("R1 por clears code", code_q, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule